// File: doc/BRIEF.md
# Table-Driven Multi-Waveform DDS Generator

This core turns a frequency word and a phase word into a stream of 10-bit samples. A wide phase accumulator steps by the frequency word on every clock and wraps silently when it overflows. Each wrap is one period of the output. The top ten accumulator bits, offset by the phase word, address a set of six 1024-point waveform tables. A 3-bit selector chooses the table that drives the registered output.

The tables are square, triangle, sine, sawtooth, amplitude-modulated carrier and double-sideband product. They are generated inside the design from the address, and only the sine table is held as a ROM. The ROM is filled at elaboration. The AM and DSB values are formed from two reads of that sine ROM: one at the address (the modulator) and one at eight times the address (the carrier).

The output frequency is f_clk·K/2^ACC_W, where K is the frequency word. K = 1 gives the finest step, and useful output stays below f_clk/2. The core has no control states: it runs freely from reset.

Top module: `dds_siggen`

## Requirements
- R1: On every clock out of reset, the accumulator adds the zero-extended 8-bit frequency word, modulo 2^ACC_W.
- R2: Overflow wraps without any flag, so the output repeats every 2^ACC_W/K clocks when K divides 2^ACC_W.
- R3: Table address = (accumulator[ACC_W-1 -: 10] + zero-extended phase word) mod 1024, captured in a register.
- R4: The output register holds the selected table value at the address of the previous cycle. The output therefore lags the accumulator by two clocks.
- R5: Select codes are 0 square, 1 triangle, 2 sine, 3 sawtooth, 4 AM, 5 DSB. Codes 6 and 7 give an output of 0.
- R6: Square value is 1023 for addresses 0..511 and 0 for 512..1023.
- R7: Triangle value is 2·a for a < 512 and 2047 − 2·a otherwise.
- R8: Sawtooth value equals the address a.
- R9: Sine value is round(511 + 511·sin(2πa/1024)), within one code.
- R10: AM value is 511 + trunc(c·(1022 + m)/1533), where c = sine(8a mod 1024) − 511 and m = sine(a) − 511.
- R11: DSB value is 512 + trunc(c·m/512), with c and m as in R10.
- R12: A synchronous active-high reset clears the accumulator, the address and the output. The first post-reset sample is table entry 0, and the next is table entry PWORD.
- R13: A change of select code appears at the output on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| fword | input | 8 | Frequency step added each clock |
| pword | input | 8 | Phase offset added to the table address |
| wsel | input | 3 | Waveform select code |
| sample | output | 10 | Registered waveform sample |

## Verification
The assertions assume that fword, pword and wsel are stable around each rising edge and are never X once reset is released. The stimulus meets this by changing every input only on the falling edge. The reset is applied for several cycles at time zero, so the past-valid flags in the assertions start from known values. The bench shortens the accumulator to 16 bits, which lets full periods and wraps occur within the run. It also steps the select code on every cycle to exercise the one-clock select latency.

// File: rtl/dds_pkg.sv
package dds_pkg;
    localparam int ADDR_W  = 10;
    localparam int DATA_W  = 10;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int N_WAVES = 6;
    localparam int MID     = (1 << (DATA_W - 1)) - 1;   // 511

    typedef enum logic [2:0] {
        W_SQUARE = 3'd0,
        W_TRI    = 3'd1,
        W_SINE   = 3'd2,
        W_SAW    = 3'd3,
        W_AM     = 3'd4,
        W_DSB    = 3'd5
    } wave_e;

    typedef logic [DATA_W-1:0] sine_rom_t [DEPTH];

    // Offset-binary sine via a Taylor series on an angle folded into [-pi, pi]
    function automatic sine_rom_t make_sine();
        sine_rom_t t;
        real x, term, s, v;
        for (int a = 0; a < DEPTH; a++) begin
            x = 2.0 * 3.14159265358979 * a / DEPTH;
            if (x > 3.14159265358979) x = x - 2.0 * 3.14159265358979;
            term = x;
            s    = x;
            for (int k = 1; k < 10; k++) begin
                term = -term * x * x / ((2.0 * k) * (2.0 * k + 1.0));
                s    = s + term;
            end
            v    = MID + MID * s + 0.5;
            t[a] = DATA_W'($rtoi(v));
        end
        return t;
    endfunction
endpackage

// File: rtl/dds_phase_accum.sv
module dds_phase_accum #(
    parameter int ACC_W  = 32,
    parameter int FW_W   = 8,
    parameter int PW_W   = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FW_W-1:0]   fword,
    input  logic [PW_W-1:0]   pword,
    output logic [ADDR_W-1:0] addr
);
    localparam int TOP = ACC_W - 1;

    logic [ACC_W-1:0] acc_q;
    logic             past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            addr  <= '0;
        end else begin
            acc_q <= acc_q + ACC_W'(fword);
            addr  <= acc_q[TOP -: ADDR_W] + ADDR_W'(pword);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R1: accumulator advances by the previous frequency word
    p_acc_step_r1: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> acc_q == $past(acc_q) + ACC_W'($past(fword)));

    // R3: address tracks previous top slice plus phase word
    p_addr_offset_r3: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> addr == $past(acc_q[TOP -: ADDR_W]) + ADDR_W'($past(pword)));
endmodule

// File: rtl/dds_wave_tables.sv
module dds_wave_tables
    import dds_pkg::*;
(
    input  logic [ADDR_W-1:0]              addr,
    output logic [N_WAVES-1:0][DATA_W-1:0] waves
);
    localparam sine_rom_t SINE = make_sine();
    localparam int HALF = DEPTH / 2;

    logic [ADDR_W-1:0] car_addr;
    int                car, modv, am_i, dsb_i;

    assign car_addr = {addr[ADDR_W-4:0], 3'b000};   // 8 carrier cycles per table

    always_comb begin
        car   = int'(SINE[car_addr]) - MID;
        modv  = int'(SINE[addr]) - MID;
        am_i  = MID + (car * (2 * MID + modv)) / (3 * MID);
        dsb_i = (MID + 1) + (car * modv) / (MID + 1);

        waves[W_SQUARE] = (int'(addr) < HALF) ? {DATA_W{1'b1}} : '0;
        waves[W_TRI]    = (int'(addr) < HALF) ? {addr[ADDR_W-2:0], 1'b0}
                                              : ~{addr[ADDR_W-2:0], 1'b0};
        waves[W_SINE]   = SINE[addr];
        waves[W_SAW]    = addr;
        waves[W_AM]     = am_i[DATA_W-1:0];
        waves[W_DSB]    = dsb_i[DATA_W-1:0];
    end
endmodule

// File: rtl/dds_out_select.sv
module dds_out_select
    import dds_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [2:0]                     wsel,
    input  logic [N_WAVES-1:0][DATA_W-1:0] waves,
    output logic [DATA_W-1:0]              sample
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst)                      sample <= '0;
        else if (int'(wsel) < N_WAVES) sample <= waves[wsel];
        else                          sample <= '0;
    end

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R5: unused codes force a zero sample
    p_unused_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(wsel) > 3'd5) |-> sample == '0);

    // R6: square output only takes its two rail values
    p_square_rails_r6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(wsel) == 3'd0) |-> (sample == '0 || sample == {DATA_W{1'b1}}));
endmodule

// File: rtl/dds_siggen.sv
module dds_siggen
    import dds_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int FW_W  = 8,
    parameter int PW_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FW_W-1:0]   fword,
    input  logic [PW_W-1:0]   pword,
    input  logic [2:0]        wsel,
    output logic [DATA_W-1:0] sample
);
    logic [ADDR_W-1:0]              addr;
    logic [N_WAVES-1:0][DATA_W-1:0] waves;
    logic                           past_ok;

    dds_phase_accum #(
        .ACC_W (ACC_W), .FW_W (FW_W), .PW_W (PW_W), .ADDR_W (ADDR_W)
    ) u_accum (
        .clk (clk), .rst (rst), .fword (fword), .pword (pword), .addr (addr)
    );

    dds_wave_tables u_tables (
        .addr (addr), .waves (waves)
    );

    dds_out_select u_select (
        .clk (clk), .rst (rst), .wsel (wsel), .waves (waves), .sample (sample)
    );

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R8: in sawtooth mode the sample repeats the previous address
    p_saw_follow_r8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(wsel) == 3'd3) |-> sample == $past(addr));
endmodule

// File: tb/sim_dds_siggen.sv
module sim_dds_siggen;
    localparam int ACC_W = 16;
    localparam int SHIFT = ACC_W - 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] fword = '0;
    logic [7:0] pword = '0;
    logic [2:0] wsel = '0;
    logic [9:0] sample;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // behavioural reference state
    longint m_acc  = 0;
    int     m_addr = 0;
    int     m_out  = 0;
    int     m_sel  = 0;

    always #5 clk = ~clk;

    dds_siggen #(.ACC_W(ACC_W)) u0 (
        .clk (clk), .rst (rst), .fword (fword), .pword (pword),
        .wsel (wsel), .sample (sample)
    );

    function automatic int ref_sin(int a);
        return $rtoi(511.0 + 511.0 * $sin(2.0 * 3.14159265358979 * a / 1024.0) + 0.5);
    endfunction

    function automatic int ref_val(int s, int a);
        int c, m;
        c = ref_sin((8 * a) % 1024) - 511;
        m = ref_sin(a) - 511;
        case (s)
            0:       return (a < 512) ? 1023 : 0;
            1:       return (a < 512) ? 2 * a : 2047 - 2 * a;
            2:       return ref_sin(a);
            3:       return a;
            4:       return 511 + (c * (1022 + m)) / 1533;
            5:       return 512 + (c * m) / 512;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(int s);
        case (s)
            0: return "R6";  1: return "R7";  2: return "R9";
            3: return "R8";  4: return "R10"; 5: return "R11";
            default: return "R5";
        endcase
    endfunction

    // reference pipeline (R1 R2 R3 R4 R12 R13)
    always @(posedge clk) begin
        if (rst) begin
            m_out = 0; m_addr = 0; m_acc = 0; m_sel = 0;
        end else begin
            m_out  = ref_val(int'(wsel), m_addr);
            m_sel  = int'(wsel);
            m_addr = (int'(m_acc >> SHIFT) + int'(pword)) % 1024;
            m_acc  = (m_acc + longint'(fword)) % (longint'(1) << ACC_W);
        end
    end

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // compare every cycle on the falling edge
    always @(negedge clk) begin
        int tol, diff;
        cyc++;
        tol  = (m_sel == 2) ? 1 : ((m_sel == 4 || m_sel == 5) ? 3 : 0);
        diff = int'(sample) - m_out;
        if (diff < 0) diff = -diff;
        n_chk++;
        if (diff > tol) begin
            n_bad++;
            $display("FAIL %s (R4 latency) cycle %0d: got %0d expected %0d",
                     rst ? "R12" : req_of(m_sel), cyc, sample, m_out);
        end
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
            finish_up();
        end
    end

    task automatic run(int k, int p, int s, int n);
        fword = 8'(k); pword = 8'(p); wsel = 3'(s);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;                 // R12: zero then entry PWORD
        run(37, 0, 0, 300);         // R6 with R1 stepping
        run(255, 100, 1, 600);      // R7 fast, R2 repeated wraps
        run(64, 5, 2, 1100);        // R9 one address per clock
        run(1, 0, 3, 200);          // R8 slow step
        run(64, 0, 3, 1100);        // R8 full period, R2
        run(64, 17, 4, 1100);       // R10
        run(64, 200, 5, 1100);      // R11, R3 offset wrap
        run(90, 0, 6, 60);          // R5 unused codes
        run(90, 0, 7, 60);
        for (int i = 0; i < 400; i++) run(41, i % 256, i % 8, 1);  // R13
        run(0, 3, 3, 50);           // R1 zero step holds address
        rst = 1'b1;                 // R12 mid-run reset
        run(50, 200, 3, 3);
        rst = 1'b0;
        run(50, 200, 3, 40);
        finish_up();
    end
endmodule